// File: doc/BRIEF.md
# Transmit Space-Request FIFO

This block is a byte-wide transmit buffer that sits behind a synchronous slave bus. It receives bytes from the system and hands them to a MAC transmit path. Software or a DMA engine writes bytes into it in one of two ways. The first is a chip-select write with the read/write line low and the FIFO's address on the address lines. The second is a dedicated FIFO data strobe with read/write low, which ignores the address lines completely. A strobe with read/write high is a receive-side read and leaves this buffer untouched. The write path never waits on anything, so transmit writes can interleave freely with receive traffic.

The drain side offers the oldest byte through a valid/ready handshake. A transfer-request output tells the DMA engine when to refill the buffer. It is based on free space, not on stored data. It asserts once free space reaches a programmable watermark of 16, 32 or 64 bytes. It is always asserted while the buffer is empty. It is held off entirely while transmit is disabled.

A write that arrives while the buffer is full is discarded. It sets a sticky overflow flag that stays set until a clear strobe.

Top module: `tx_space_fifo`

## Requirements
- R1: After reset the buffer is empty, `out_valid` and `ovf_flag` are 0, and `xfer_req` equals `tx_en`.
- R2: A cycle with `bus_sel`=1, `bus_rd`=0 and `bus_addr`=`FIFO_ADDR` (default 1) appends `bus_wdata`. A chip-select write to any other address leaves the buffer unchanged.
- R3: A cycle with `fifo_stb`=1 and `bus_rd`=0 appends `bus_wdata`, whatever the values of `bus_addr` and `bus_sel`.
- R4: A cycle with `fifo_stb`=1 and `bus_rd`=1 does not change the buffer.
- R5: When the decoded write and the strobe write occur in the same cycle, exactly one byte is appended.
- R6: Bytes leave in write order. `out_valid` is 1 exactly when the buffer holds data, and `out_data` is the oldest byte. A byte is removed on a clock edge where `out_valid` and `out_ready` are both 1. While `out_ready` is 0, `out_data` holds its value.
- R7: `xfer_req` is 0 whenever `tx_en` is 0.
- R8: With `tx_en`=1, `xfer_req` is 1 whenever the buffer is empty.
- R9: With `tx_en`=1, `xfer_req` is 1 exactly when free space (DEPTH minus occupancy) is at least the watermark. The watermark is 16 for `wm_sel`=00, 32 for 01, and 64 for 10 or 11, each capped at DEPTH. The output follows the occupancy in the same cycle that the occupancy changes.
- R10: A write while the buffer is full (occupancy as it stood before the edge) is discarded, even if a byte drains on the same edge.
- R11: A discarded write sets `ovf_flag`, which stays 1 until a cycle with `ovf_clr`=1. If a discarded write and `ovf_clr` occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Chip select for a decoded bus access |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Register address for decoded accesses |
| fifo_stb | input | 1 | FIFO data strobe; bypasses the address decode |
| bus_wdata | input | 8 | Write data |
| tx_en | input | 1 | Transmit enable; gates the request |
| wm_sel | input | 2 | Free-space watermark select |
| ovf_clr | input | 1 | Clears the overflow flag |
| out_valid | output | 1 | A byte is available to the MAC |
| out_data | output | 8 | Oldest buffered byte |
| out_ready | input | 1 | The MAC accepts the byte |
| xfer_req | output | 1 | Transfer request based on free space |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The assertions assume that the bus inputs and `out_ready` are known and stable around each rising edge. They also assume that reset is held low for at least one edge before any access. The hold check on `out_data` further assumes that the MAC side never withdraws `out_ready` in the middle of a transfer in a way that matters for data. The bench drives every input only at the falling edge and holds reset for several cycles before the first access. A behavioural queue model predicts every output on every cycle, both in the directed phases and in a long random phase whose inputs all change only at the falling edge.

// File: rtl/tx_space_fifo.sv
module tx_space_fifo #(
  parameter int          DEPTH     = 64,
  parameter int          ADDR_W    = 5,
  parameter int unsigned FIFO_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              fifo_stb,
  input  logic [7:0]        bus_wdata,
  input  logic              tx_en,
  input  logic [1:0]        wm_sel,
  input  logic              ovf_clr,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              xfer_req,
  output logic              ovf_flag
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int WM_LO = (DEPTH < 16) ? DEPTH : 16;
  localparam int WM_MID = (DEPTH < 32) ? DEPTH : 32;
  localparam int WM_HI = (DEPTH < 64) ? DEPTH : 64;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used, free, thr;
  logic             dec_wr, stb_wr, wr_req, full, empty, push, pop;

  assign dec_wr = bus_sel && !bus_rd && (bus_addr == FIFO_ADDR[ADDR_W-1:0]);
  assign stb_wr = fifo_stb && !bus_rd;
  assign wr_req = dec_wr || stb_wr;

  assign empty = (used == '0);
  assign full  = (used == CNT_W'(DEPTH));
  assign push  = wr_req && !full;
  assign pop   = !empty && out_ready;
  assign free  = CNT_W'(DEPTH) - used;

  always_comb begin
    case (wm_sel)
      2'b00:   thr = CNT_W'(WM_LO);
      2'b01:   thr = CNT_W'(WM_MID);
      default: thr = CNT_W'(WM_HI);
    endcase
  end

  assign xfer_req  = tx_en && (empty || (free >= thr));
  assign out_valid = !empty;
  assign out_data  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      used     <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   used <= used + 1'b1;
        2'b01:   used <= used - 1'b1;
        default: used <= used;
      endcase
      if (wr_req && full) ovf_flag <= 1'b1;
      else if (ovf_clr)   ovf_flag <= 1'b0;
    end
  end

endmodule

module tx_space_fifo_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              fifo_stb,
  input logic              tx_en,
  input logic              ovf_clr,
  input logic              out_valid,
  input logic [7:0]        out_data,
  input logic              out_ready,
  input logic              xfer_req,
  input logic              ovf_flag
);

  AST_REQ_GATED_BY_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !xfer_req); // R7

  AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !out_valid) |-> xfer_req); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R11

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_RD_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_stb && bus_rd && !bus_sel && !out_valid) |=> !out_valid); // R4

  AST_STROBE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_stb && !bus_rd && !out_valid) |=> out_valid); // R3

endmodule

bind tx_space_fifo tx_space_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .fifo_stb(fifo_stb), .tx_en(tx_en), .ovf_clr(ovf_clr),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
  .xfer_req(xfer_req), .ovf_flag(ovf_flag)
);

// File: tb/test_tx_space_fifo.sv
`timescale 1ns/1ps
module test_tx_space_fifo;
  localparam int DEPTH = 64;
  localparam int AW = 5;
  localparam int FA = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_rd = 1'b1, fifo_stb = 1'b0, tx_en = 1'b1, ovf_clr = 1'b0, out_ready = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [1:0] wm_sel = 2'b00;
  logic out_valid, xfer_req, ovf_flag;
  logic [7:0] out_data;

  tx_space_fifo #(.DEPTH(DEPTH), .ADDR_W(AW), .FIFO_ADDR(FA)) i_tx_space_fifo (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .fifo_stb(fifo_stb), .bus_wdata(bus_wdata), .tx_en(tx_en), .wm_sel(wm_sel),
    .ovf_clr(ovf_clr), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .xfer_req(xfer_req), .ovf_flag(ovf_flag));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int mq[$];
  bit movf = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  function automatic int thr_of(logic [1:0] s);
    int t;
    t = (s == 2'b00) ? 16 : (s == 2'b01) ? 32 : 64;
    return (t > DEPTH) ? DEPTH : t;
  endfunction

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int ev, er;
    ev = (mq.size() > 0);
    check("out_valid (R6)", int'(out_valid), ev);
    if (ev == 1) check("out_data (R6)", int'(out_data), mq[0]);
    er = tx_en && (mq.size() == 0 || (DEPTH - mq.size()) >= thr_of(wm_sel));
    check(!tx_en ? "xfer_req (R7)" : (mq.size() == 0 ? "xfer_req (R8)" : "xfer_req (R9)"),
          int'(xfer_req), er);
    check("ovf_flag (R11)", int'(ovf_flag), int'(movf));
  endtask

  task automatic cyc();
    bit wr, was_full, pop;
    @(posedge clk);
    if (!rst_n) begin
      mq.delete();
      movf = 1'b0;
    end else begin
      wr = (bus_sel && !bus_rd && bus_addr == AW'(FA)) || (fifo_stb && !bus_rd);
      was_full = (mq.size() == DEPTH);
      pop = (mq.size() > 0) && out_ready;
      if (pop) void'(mq.pop_front());
      if (wr && was_full) movf = 1'b1;
      else if (ovf_clr) movf = 1'b0;
      if (wr && !was_full) mq.push_back(int'(bus_wdata));
    end
    @(negedge clk);
    if (rst_n) compare();
  endtask

  task automatic idle_bus();
    bus_sel = 1'b0; fifo_stb = 1'b0; bus_rd = 1'b1; ovf_clr = 1'b0;
  endtask

  task automatic wr_dec(logic [AW-1:0] a, logic [7:0] d);
    bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    cyc(); idle_bus();
  endtask

  task automatic wr_stb(logic rd, logic [7:0] d);
    fifo_stb = 1'b1; bus_rd = rd; bus_addr = AW'($urandom); bus_wdata = d;
    cyc(); idle_bus();
  endtask

  task automatic drain();
    out_ready = 1'b1;
    for (int i = 0; i < DEPTH + 4; i++) cyc();
    out_ready = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) cyc();
    @(negedge clk); rst_n = 1'b1;
    tag = "R1";
    check("empty after reset R1", int'(out_valid), 0);
    check("req after reset R1", int'(xfer_req), 1);
    check("ovf after reset R1", int'(ovf_flag), 0);

    tag = "R7"; tx_en = 1'b0;
    wr_stb(1'b0, 8'h11); cyc(); drain(); tx_en = 1'b1;

    tag = "R2";
    wr_dec(AW'(FA), 8'hA1);
    wr_dec(AW'(FA + 1), 8'hA2);
    wr_dec(AW'(0), 8'hA3);
    wr_dec(AW'(FA), 8'hA4);
    check("decoded writes kept R2", mq.size(), 2);

    tag = "R3";
    wr_stb(1'b0, 8'hB1);
    bus_sel = 1'b1; wr_stb(1'b0, 8'hB2);

    tag = "R4";
    wr_stb(1'b1, 8'hC1);
    wr_stb(1'b1, 8'hC2);

    tag = "R5";
    bus_sel = 1'b1; bus_rd = 1'b0; bus_addr = AW'(FA); fifo_stb = 1'b1; bus_wdata = 8'hD5;
    cyc(); idle_bus();
    check("one entry for dual write R5", mq.size(), 5);

    tag = "R6";
    for (int i = 0; i < 12; i++) begin out_ready = i[0]; cyc(); end
    drain();

    for (int w = 0; w < 4; w++) begin
      wm_sel = 2'(w);
      tag = "R9";
      for (int i = 0; i < DEPTH; i++) wr_stb(1'b0, 8'(i + w));
      tag = "R10";
      wr_stb(1'b0, 8'hEE);
      wr_stb(1'b0, 8'hEF);
      out_ready = 1'b1; wr_stb(1'b0, 8'hF0); out_ready = 1'b0;
      check("full drop keeps ovf R10", int'(ovf_flag), 1);
      tag = "R11";
      cyc(); cyc();
      ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
      wr_stb(1'b0, 8'hF1);
      ovf_clr = 1'b1; wr_stb(1'b0, 8'hF2);
      check("set wins over clear R11", int'(ovf_flag), 1);
      ovf_clr = 1'b1; cyc(); ovf_clr = 1'b0;
      tag = "R6";
      drain();
    end

    tag = "R6";
    for (int i = 0; i < 6000; i++) begin
      bus_sel = 1'($urandom); bus_rd = 1'($urandom); bus_addr = AW'($urandom % 3);
      fifo_stb = (($urandom % 3) == 0); bus_wdata = 8'($urandom);
      tx_en = (($urandom % 8) != 0); wm_sel = 2'($urandom);
      ovf_clr = (($urandom % 16) == 0); out_ready = (($urandom % 4) == 0);
      cyc();
    end
    idle_bus();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule